// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the oversampling tick of a serial port from the peripheral clock. The programmed divisor has a whole part and a part in sixty-fourths, and it stands for the peripheral clock divided by sixteen times the wanted bit rate. Each 16x period lasts either the whole divisor or one cycle more. A six-bit phase accumulator chooses which periods get the extra cycle, so the average period equals the divisor exactly. Every sixteenth oversampling tick also raises a bit-period tick. Software works out the two divisor parts. The block only takes them in through simple write strobes.

A divisor write goes to a staging register and leaves the running rate alone. A separate line-control update strobe copies both staged parts into the active divisor in one step. The same strobe restarts the period counter, the accumulator and the tick counter, so the first period under the new rate is a whole one. A whole part of zero cannot be used. If it is staged, the update loads the slowest-legal-limit's opposite, the fastest setting: whole part one, fraction zero. Dropping the enable input clears all counters and holds them at zero.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset both active divisor parts are whole 1 and fraction 0, and both tick outputs are low. Once enabled with no writes, `tick16_o` is high on every cycle.
- R2: With whole part N of 2 or more and fraction 0, `tick16_o` is a one-cycle pulse that repeats every N cycles.
- R3: With fraction F (0..63), period k counted from 0 after enable or update lasts N + floor((k+1)F/64) - floor(kF/64) cycles. Any 64 consecutive periods therefore total 64N+F cycles.
- R4: Writes through `div_int_we_i` / `div_frac_we_i` change only the staging registers. The tick spacing does not change until `line_update_i` is sampled high.
- R5: `line_update_i` loads the staged divisor and restarts every counter. `tick16_o` is low in the following cycle. The first tick appears on the P-th rising edge after the update edge, where P is the new whole part. The bit tick comes on the 16th tick after that.
- R6: An update with a staged whole part of 0 loads whole part 1 and fraction 0, whatever fraction was staged. The active whole part is never 0.
- R7: `bit_tick_o` is high only together with `tick16_o`, on the 16th, 32nd, ... tick after enable or update.
- R8: While `en_i` is low, both outputs are low from the next cycle on. After `en_i` rises again, the first tick comes on the N-th rising edge at which `en_i` is sampled high.
- R9: A whole part of 65535 gives a first period of exactly 65535 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; when low, counters clear and hold |
| div_int_we_i | input | 1 | Write strobe for the staged whole divisor |
| div_int_wdata_i | input | INT_W | Staged whole divisor value |
| div_frac_we_i | input | 1 | Write strobe for the staged fractional divisor |
| div_frac_wdata_i | input | FRAC_W | Staged fractional divisor value, in 1/64 steps |
| line_update_i | input | 1 | Line-control update strobe; loads the staged divisor and restarts counting |
| tick16_o | output | 1 | Oversampling tick at 16x the bit rate |
| bit_tick_o | output | 1 | Bit-period tick, on every 16th oversampling tick |

## Verification
The bench drives whole-only divisors of 1, 4, 5 and 7, and fractional settings of 3+21/64 and 2+63/64. The first set separates the base period count from the accumulator. The second checks the exact cycles where the extra cycle lands, and the 64-period total. Writes made while the block runs without an update show that staging is isolated from the active divisor. An update made partway through a period shows that the period counter and the bit-tick phase restart. A staged zero, an enable drop mid-period, and the 65535 limit cover the clamp, the clearing of counters and the counter width.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
    localparam int unsigned DEF_INT_W  = 16;
    localparam int unsigned DEF_FRAC_W = 6;
    localparam int unsigned DEF_OVS    = 16;

    // sequencing controls shared by every counter stage
    typedef struct packed {
        logic run;      // counting allowed
        logic restart;  // divisor reload: clear and start afresh
    } fbg_ctl_t;
endpackage

// File: rtl/fbg_div_regs.sv
module fbg_div_regs
    import fbg_pkg::*;
#(
    parameter int unsigned INT_W  = DEF_INT_W,
    parameter int unsigned FRAC_W = DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_we,
    input  logic [INT_W-1:0]  int_wdata,
    input  logic              frac_we,
    input  logic [FRAC_W-1:0] frac_wdata,
    input  logic              commit,
    output logic [INT_W-1:0]  act_int,
    output logic [FRAC_W-1:0] act_frac
);
    localparam logic [INT_W-1:0] INT_ONE = INT_W'(1);

    typedef struct packed {
        logic [INT_W-1:0]  stg_int;
        logic [FRAC_W-1:0] stg_frac;
        logic [INT_W-1:0]  run_int;
        logic [FRAC_W-1:0] run_frac;
    } div_regs_t;

    div_regs_t r_d, r_q;
    logic      stg_zero;

    always_comb begin
        r_d      = r_q;
        stg_zero = (r_q.stg_int == '0);
        if (int_we) begin
            r_d.stg_int = int_wdata;
        end
        if (frac_we) begin
            r_d.stg_frac = frac_wdata;
        end
        if (commit) begin
            // a zero whole part is illegal: fall back to the fastest legal rate
            r_d.run_int  = stg_zero ? INT_ONE : r_q.stg_int;
            r_d.run_frac = stg_zero ? '0 : r_q.stg_frac;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{stg_int: INT_ONE, stg_frac: '0, run_int: INT_ONE, run_frac: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign act_int  = r_q.run_int;
    assign act_frac = r_q.run_frac;
endmodule

// File: rtl/fbg_frac_accum.sv
module fbg_frac_accum
    import fbg_pkg::*;
#(
    parameter int unsigned FRAC_W = DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fbg_ctl_t          ctl,
    input  logic              advance,
    input  logic [FRAC_W-1:0] frac,
    output logic              carry
);
    localparam int unsigned SUM_W = FRAC_W + 1;

    typedef struct packed {
        logic [FRAC_W-1:0] phase;
    } acc_t;

    acc_t             a_d, a_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        a_d   = a_q;
        sum   = {1'b0, a_q.phase} + {1'b0, frac};
        // the wrap of the phase lengthens the current period by one cycle
        carry = sum[FRAC_W];
        if (!ctl.run || ctl.restart) begin
            a_d.phase = '0;
        end else if (advance) begin
            a_d.phase = sum[FRAC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end
endmodule

// File: rtl/fbg_tick_counter.sv
module fbg_tick_counter
    import fbg_pkg::*;
#(
    parameter int unsigned INT_W = DEF_INT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fbg_ctl_t         ctl,
    input  logic [INT_W-1:0] div_int,
    input  logic             carry,
    output logic             period_end,
    output logic             tick_o
);
    // one spare bit: a period can last the whole part plus one
    localparam int unsigned CNT_W = INT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } cnt_t;

    cnt_t             c_d, c_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        c_d        = c_q;
        last       = {1'b0, div_int} + CNT_W'(carry) - CNT_W'(1);
        period_end = (c_q.cnt == last);
        if (!ctl.run || ctl.restart) begin
            c_d.cnt  = '0;
            c_d.tick = 1'b0;
        end else begin
            c_d.cnt  = period_end ? '0 : c_q.cnt + CNT_W'(1);
            c_d.tick = period_end;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign tick_o = c_q.tick;
endmodule

// File: rtl/fbg_bit_counter.sv
module fbg_bit_counter
    import fbg_pkg::*;
#(
    parameter int unsigned OVS = DEF_OVS
) (
    input  logic     clk,
    input  logic     rst_n,
    input  fbg_ctl_t ctl,
    input  logic     tick_ev,
    output logic     bit_tick_o
);
    localparam int unsigned SUB_W    = (OVS > 2) ? $clog2(OVS) : 1;
    localparam bit          IS_POW2  = (OVS == (1 << SUB_W));
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic             bit_tick;
    } sub_t;

    sub_t             s_d, s_q;
    logic             is_last;
    logic [SUB_W-1:0] sub_inc;

    assign is_last = (s_q.sub == SUB_LAST);

    generate
        if (IS_POW2) begin : g_wrap_free
            assign sub_inc = s_q.sub + SUB_W'(1);
        end else begin : g_wrap_cmp
            assign sub_inc = is_last ? '0 : s_q.sub + SUB_W'(1);
        end
    endgenerate

    always_comb begin
        s_d = s_q;
        if (!ctl.run || ctl.restart) begin
            s_d.sub      = '0;
            s_d.bit_tick = 1'b0;
        end else begin
            s_d.bit_tick = tick_ev && is_last;
            if (tick_ev) begin
                s_d.sub = sub_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bit_tick_o = s_q.bit_tick;
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import fbg_pkg::*;
#(
    parameter int unsigned INT_W  = DEF_INT_W,
    parameter int unsigned FRAC_W = DEF_FRAC_W,
    parameter int unsigned OVS    = DEF_OVS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              div_int_we_i,
    input  logic [INT_W-1:0]  div_int_wdata_i,
    input  logic              div_frac_we_i,
    input  logic [FRAC_W-1:0] div_frac_wdata_i,
    input  logic              line_update_i,
    output logic              tick16_o,
    output logic              bit_tick_o
);
    fbg_ctl_t          ctl;
    logic [INT_W-1:0]  div_int_act;
    logic [FRAC_W-1:0] div_frac_act;
    logic              frac_carry;
    logic              period_end;

    always_comb begin
        ctl = '{run: en_i, restart: line_update_i};
    end

    fbg_div_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .int_we     (div_int_we_i),
        .int_wdata  (div_int_wdata_i),
        .frac_we    (div_frac_we_i),
        .frac_wdata (div_frac_wdata_i),
        .commit     (line_update_i),
        .act_int    (div_int_act),
        .act_frac   (div_frac_act)
    );

    fbg_frac_accum #(.FRAC_W(FRAC_W)) u_frac_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl     (ctl),
        .advance (period_end),
        .frac    (div_frac_act),
        .carry   (frac_carry)
    );

    fbg_tick_counter #(.INT_W(INT_W)) u_tick_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl        (ctl),
        .div_int    (div_int_act),
        .carry      (frac_carry),
        .period_end (period_end),
        .tick_o     (tick16_o)
    );

    fbg_bit_counter #(.OVS(OVS)) u_bit_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl        (ctl),
        .tick_ev    (period_end),
        .bit_tick_o (bit_tick_o)
    );
endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
    parameter int unsigned INT_W  = 16,
    parameter int unsigned FRAC_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic              line_update_i,
    input logic              tick16_o,
    input logic              bit_tick_o,
    input logic [INT_W-1:0]  act_int,
    input logic [FRAC_W-1:0] act_frac
);
    localparam int unsigned GAP_W = INT_W + 1;

    // cycles since the last oversampling tick, restart or idle
    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (!en_i || line_update_i || tick16_o) begin
            gap_q <= '0;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    // R3: no period runs longer than the whole part plus the carry cycle
    assert_gap_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick16_o |-> (gap_q <= {1'b0, act_int}));

    // R2: with a whole part above one the tick is a single-cycle pulse
    assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick16_o && act_int > INT_W'(1)) |=> !tick16_o);

    // R4: the active divisor moves only on an update strobe
    assert_active_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !line_update_i |=> ($stable(act_int) && $stable(act_frac)));

    // R5: an update clears the tick in the next cycle
    assert_update_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        line_update_i |=> !tick16_o);

    // R6: the active whole part is never zero
    assert_int_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        act_int != '0);

    // R7: the bit tick rides on an oversampling tick
    assert_bit_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick_o |-> tick16_o);

    // R8: disabled means quiet outputs from the next cycle
    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!tick16_o && !bit_tick_o));
endmodule

bind frac_baud_gen frac_baud_gen_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (en_i),
    .line_update_i (line_update_i),
    .tick16_o      (tick16_o),
    .bit_tick_o    (bit_tick_o),
    .act_int       (div_int_act),
    .act_frac      (div_frac_act)
);

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic        div_int_we_i = 1'b0;
    logic [15:0] div_int_wdata_i = '0;
    logic        div_frac_we_i = 1'b0;
    logic [5:0]  div_frac_wdata_i = '0;
    logic        line_update_i = 1'b0;
    logic        tick16_o;
    logic        bit_tick_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int c0     = 0;
    bit done   = 0;
    int stamps [0:79];
    bit bflag  [0:79];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    frac_baud_gen u_frac_baud_gen (
        .clk (clk), .rst_n (rst_n), .en_i (en_i),
        .div_int_we_i (div_int_we_i), .div_int_wdata_i (div_int_wdata_i),
        .div_frac_we_i (div_frac_we_i), .div_frac_wdata_i (div_frac_wdata_i),
        .line_update_i (line_update_i),
        .tick16_o (tick16_o), .bit_tick_o (bit_tick_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_period(input int n, input int f, input int k);
        return n + ((k + 1) * f) / 64 - (k * f) / 64;
    endfunction

    task automatic set_div(input int n, input int f);
        div_int_we_i = 1'b1; div_int_wdata_i = n[15:0];
        div_frac_we_i = 1'b1; div_frac_wdata_i = f[5:0];
        @(negedge clk);
        div_int_we_i = 1'b0; div_frac_we_i = 1'b0;
    endtask

    task automatic do_update();
        line_update_i = 1'b1;
        @(negedge clk);
        line_update_i = 1'b0;
    endtask

    // gather n tick timestamps starting now; c0 marks the start
    task automatic collect(input int n, input int limit, input string req);
        int idx = 0;
        int guard = 0;
        c0 = cyc;
        while (idx < n && guard < limit) begin
            @(posedge clk); @(negedge clk);
            guard++;
            if (tick16_o) begin
                stamps[idx] = cyc;
                bflag[idx]  = bit_tick_o;
                idx++;
            end
        end
        chk(idx == n, {req, " tick count"}, idx, n);
    endtask

    // first latency, spacings and bit-tick placement from a fresh start
    task automatic check_run(input int n, input int f, input int cnt, input string req);
        collect(cnt, cnt * (n + 2) + 20, req);
        chk(stamps[0] - c0 == n, {req, " first period"}, stamps[0] - c0, n);
        for (int j = 1; j < cnt; j++) begin
            chk(stamps[j] - stamps[j-1] == exp_period(n, f, j), {req, " period"},
                stamps[j] - stamps[j-1], exp_period(n, f, j));
        end
        for (int j = 0; j < cnt; j++) begin
            chk(bflag[j] == ((j + 1) % 16 == 0), "R7 bit tick placement",
                int'(bflag[j]), int'((j + 1) % 16 == 0));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(tick16_o == 1'b0, "R1 tick in reset", int'(tick16_o), 0);
        chk(bit_tick_o == 1'b0, "R1 bit tick in reset", int'(bit_tick_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tick16_o == 1'b0, "R1 tick idle after reset", int'(tick16_o), 0);
        en_i = 1'b1;
        check_run(1, 0, 20, "R1");
        en_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_integer();
        set_div(7, 0);
        do_update();
        en_i = 1'b1;
        check_run(7, 0, 48, "R2");
        en_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_fraction();
        set_div(3, 21);
        do_update();
        en_i = 1'b1;
        check_run(3, 21, 65, "R3");
        chk(stamps[64] - stamps[0] == 64 * 3 + 21, "R3 sixty-four period total",
            stamps[64] - stamps[0], 64 * 3 + 21);
        en_i = 1'b0;
        @(negedge clk);
        set_div(2, 63);
        do_update();
        en_i = 1'b1;
        check_run(2, 63, 20, "R3");
        en_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_staging();
        set_div(5, 0);
        do_update();
        en_i = 1'b1;
        collect(5, 60, "R4 lead-in");
        set_div(9, 10);
        collect(20, 200, "R4");
        for (int j = 1; j < 20; j++) begin
            chk(stamps[j] - stamps[j-1] == 5, "R4 staged write ignored",
                stamps[j] - stamps[j-1], 5);
        end
        @(negedge clk); @(negedge clk);
        do_update();
        check_run(9, 10, 20, "R5");
        en_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_zero();
        set_div(0, 5);
        do_update();
        en_i = 1'b1;
        check_run(1, 0, 20, "R6");
        en_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_disable();
        set_div(4, 0);
        do_update();
        en_i = 1'b1;
        collect(3, 40, "R8 lead-in");
        @(negedge clk); @(negedge clk);
        en_i = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(tick16_o == 1'b0 && bit_tick_o == 1'b0, "R8 quiet while disabled",
                int'({tick16_o, bit_tick_o}), 0);
        end
        en_i = 1'b1;
        check_run(4, 0, 17, "R8");
        en_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_max();
        set_div(65535, 0);
        do_update();
        en_i = 1'b1;
        collect(1, 65600, "R9");
        chk(stamps[0] - c0 == 65535, "R9 maximum whole period", stamps[0] - c0, 65535);
        en_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_integer();
        t_fraction();
        t_staging();
        t_zero();
        t_disable();
        t_max();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule